// File: doc/BRIEF.md
# Memory Traffic Generator and Checker

This block exercises a 64-bit memory port with programmable passes of write and read traffic and checks every word that comes back. Software chooses how many consecutive word addresses a pass covers, which data source fills the words and which kind of traffic a pass carries. Once a run starts, the block walks the addresses upward from zero. For each accepted write it hands the source word to the port. On readback it rebuilds the same word sequence and compares each returned word against it.

Two error counters cover a run. One counts the mismatches seen on readback. The other counts the deliberate corruptions made at the request of software, each of which flips bit 0 of exactly one word. Two byte counters record written and read traffic, from which software can derive throughput.

The memory side is a valid/ready request channel. Read data returns in order and at a fixed latency on a separate valid/data response channel.

Top module: `memtg_top`

## Requirements
- R1: After reset `busy` and `memReqValid` are 0, and `errDetected`, `errInjected`, `bytesWritten` and `bytesRead` are all 0.
- R2: `startRun` is taken only while `busy` is 0. A pass covers word addresses 0 to N-1, each requested once in ascending order. N is `cfgNumAddr`, with values below 2 treated as 2 and values above 524288 treated as 524288. A stalled request holds its address and type until it is accepted.
- R3: The traffic mode is `cfgMode`: 0 or 3 means write all N addresses and then read them back; 1 means read only; 2 means write only. `busy` is 1 from the cycle after the start until the last write is accepted (write only) or the last read response arrives.
- R4: With `cfgSrc`=0, bits 31:0 and bits 63:32 each hold {1'b0, s}, where s is a 31-bit LFSR. Its seed is 31'h2AC35D17 for the low half and 31'h39D26C26 for the high half. Each step shifts left and feeds in s[30]^s[27]. The generator takes 32 steps per word. The checking generator restarts from the seeds for every run, so it reproduces the write sequence.
- R5: With `cfgSrc`=1, the word for address a is 64'h0123456789ABCDEF rotated left by 4*a[3:0] bits.
- R6: With `cfgSrc`=2 or 3, the word for address a is a*64'h9E3779B97F4A7C15 + `cfgPass`, modulo 2^64.
- R7: Each read response that differs from its expected word increments `errDetected` by one.
- R8: An injection request taken during the write phase inverts bit 0 of the next accepted write word and increments `errInjected` by one.
- R9: An injection request pending during the read phase inverts bit 0 of the next expected word, which yields exactly one mismatch, and increments `errInjected` by one.
- R10: Injection requests are taken only while `busy` is 1. Up to 15 can be pending, and each pending request corrupts its own word. Requests still pending when a run ends are discarded.
- R11: `clearErr` sets `errDetected` and `errInjected` to 0 on the next cycle and takes priority over an increment in the same cycle.
- R12: `bytesWritten` grows by 8 per accepted write and `bytesRead` by 8 per read response. Both saturate at 2^32-1, and both return to 0 when a run starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startRun | input | 1 | Start a run with the current configuration |
| cfgNumAddr | input | 20 | Word addresses per pass |
| cfgMode | input | 2 | Traffic mode |
| cfgSrc | input | 2 | Data source select |
| cfgPass | input | 16 | Pass index added by the arithmetic source |
| injectReq | input | 1 | Request one single-word corruption |
| clearErr | input | 1 | Zero both error counters |
| memReqValid | output | 1 | Request valid |
| memReqReady | input | 1 | Request accepted by memory |
| memReqWrite | output | 1 | 1 = write, 0 = read |
| memReqAddr | output | 19 | Word address |
| memReqData | output | 64 | Write data |
| memRspValid | input | 1 | Read response valid |
| memRspData | input | 64 | Read response data |
| busy | output | 1 | Run in progress |
| errDetected | output | 32 | Mismatches seen on readback |
| errInjected | output | 32 | Corruptions performed |
| bytesWritten | output | 32 | Bytes written in the current run |
| bytesRead | output | 32 | Bytes read in the current run |

## Verification
On every cycle the assertions check several invariants. Requests stay within the pass range and hold steady while stalled. The pattern registers never lock up at zero. Each error counter moves by at most one per cycle and holds while idle. A clear always lands on zero, and the byte counters never wrap. Only the bench scenarios can show the correctness of the data words themselves. The same holds for the readback comparison and the routing of an injected error to the write word or to the expected word. Clamping, refusal of a second start and discarding of idle requests are also left to the scenarios. A behavioural model covers these cycle by cycle.

// File: rtl/memtg_pkg.sv
package memtg_pkg;

  localparam logic [1:0] MODE_WR_RD   = 2'd0;
  localparam logic [1:0] MODE_RD_ONLY = 2'd1;
  localparam logic [1:0] MODE_WR_ONLY = 2'd2;

  localparam logic [1:0] SRC_PRBS  = 2'd0;
  localparam logic [1:0] SRC_TABLE = 2'd1;

  localparam logic [30:0] PRBS_SEED0     = 31'h2AC35D17;
  localparam logic [30:0] PRBS_SEED_STEP = 31'h0F0F0F0F;
  localparam logic [63:0] TABLE_BASE     = 64'h0123456789ABCDEF;
  localparam logic [63:0] ARITH_MULT     = 64'h9E3779B97F4A7C15;

  typedef enum logic [1:0] {ST_IDLE, ST_WR, ST_RD, ST_DRAIN} ctrlState_t;

  typedef struct packed {
    logic runStart;
    logic runEnd;
    logic wrPhase;
    logic wrFire;
    logic rspFire;
    logic busy;
  } ctrlStrobe_t;

  function automatic logic [30:0] prbsStep(input logic [30:0] s);
    logic [30:0] t;
    t = s;
    for (int k = 0; k < 32; k++) t = {t[29:0], t[30] ^ t[27]};
    return t;
  endfunction

  function automatic logic [63:0] tableWord(input logic [3:0] i);
    logic [63:0] w;
    w = TABLE_BASE;
    for (int k = 0; k < 16; k++)
      if (k < int'(i)) w = {w[59:0], w[63:60]};
    return w;
  endfunction

endpackage

// File: rtl/memtg_pattern.sv
module memtg_pattern
  import memtg_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int IDX_W  = 19,
  parameter int PASS_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              restart,
  input  logic              advance,
  input  logic [1:0]        src,
  input  logic [IDX_W-1:0]  idx,
  input  logic [PASS_W-1:0] pass,
  output logic [DATA_W-1:0] word
);
  localparam int LANES = DATA_W / 32;
  localparam logic [DATA_W-1:0] MULT = DATA_W'(ARITH_MULT);

  logic [DATA_W-1:0] prbsWord;

  for (genvar g = 0; g < LANES; g++) begin : gLane
    localparam logic [30:0] SEED = PRBS_SEED0 + 31'(g) * PRBS_SEED_STEP;
    logic [30:0] lfsr;
    always_ff @(posedge clk) begin
      if (!rstN || restart) lfsr <= SEED;
      else if (advance)     lfsr <= prbsStep(lfsr);
    end
    assign prbsWord[g*32 +: 32] = {1'b0, lfsr};

    // R4: an all-zero state would freeze the sequence
    a_r4_lfsr_alive: assert property (@(posedge clk) disable iff (!rstN)
      lfsr != '0);
  end

  always_comb begin
    case (src)
      SRC_PRBS:  word = prbsWord;
      SRC_TABLE: word = DATA_W'(tableWord(idx[3:0]));
      default:   word = DATA_W'(idx) * MULT + DATA_W'(pass);
    endcase
  end
endmodule

// File: rtl/memtg_ctrl.sv
module memtg_ctrl
  import memtg_pkg::*;
#(
  parameter int ADDR_W = 19,
  parameter int PASS_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startRun,
  input  logic [ADDR_W:0]   cfgNumAddr,
  input  logic [1:0]        cfgMode,
  input  logic [1:0]        cfgSrc,
  input  logic [PASS_W-1:0] cfgPass,
  input  logic              memReqReady,
  input  logic              memRspValid,
  output logic              memReqValid,
  output logic              memReqWrite,
  output logic [ADDR_W-1:0] memReqAddr,
  output logic [ADDR_W-1:0] chkIdx,
  output ctrlStrobe_t       st,
  output logic [1:0]        srcSel,
  output logic [PASS_W-1:0] passSel
);
  localparam int CNT_W = ADDR_W + 1;
  localparam logic [CNT_W-1:0] MAX_N = CNT_W'(1) << ADDR_W;
  localparam logic [CNT_W-1:0] MIN_N = CNT_W'(2);

  ctrlState_t state;
  logic [CNT_W-1:0]  numAddr, rspCnt;
  logic [ADDR_W-1:0] reqAddr;
  logic [1:0]        modeQ;
  logic reqFire, rspFire, lastReq, lastRsp, wrOnly, runStart, runEnd;

  function automatic logic [CNT_W-1:0] clampN(input logic [CNT_W-1:0] n);
    if (n < MIN_N) return MIN_N;
    if (n > MAX_N) return MAX_N;
    return n;
  endfunction

  assign memReqValid = (state == ST_WR) || (state == ST_RD);
  assign memReqWrite = (state == ST_WR);
  assign memReqAddr  = reqAddr;
  assign chkIdx      = rspCnt[ADDR_W-1:0];

  assign reqFire  = memReqValid && memReqReady;
  assign rspFire  = memRspValid && ((state == ST_RD) || (state == ST_DRAIN));
  assign lastReq  = ({1'b0, reqAddr} == numAddr - CNT_W'(1));
  assign lastRsp  = (rspCnt == numAddr - CNT_W'(1));
  assign wrOnly   = (modeQ == MODE_WR_ONLY);
  assign runStart = startRun && (state == ST_IDLE);
  assign runEnd   = ((state == ST_WR) && reqFire && lastReq && wrOnly) || (rspFire && lastRsp);

  assign st.runStart = runStart;
  assign st.runEnd   = runEnd;
  assign st.wrPhase  = (state == ST_WR);
  assign st.wrFire   = reqFire && (state == ST_WR);
  assign st.rspFire  = rspFire;
  assign st.busy     = (state != ST_IDLE);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      numAddr <= MIN_N;
      rspCnt  <= '0;
      reqAddr <= '0;
      modeQ   <= MODE_WR_RD;
      srcSel  <= SRC_PRBS;
      passSel <= '0;
    end else begin
      case (state)
        ST_IDLE: if (startRun) begin
          numAddr <= clampN(cfgNumAddr);
          modeQ   <= cfgMode;
          srcSel  <= cfgSrc;
          passSel <= cfgPass;
          reqAddr <= '0;
          rspCnt  <= '0;
          state   <= (cfgMode == MODE_RD_ONLY) ? ST_RD : ST_WR;
        end
        ST_WR: if (reqFire) begin
          if (lastReq) begin
            reqAddr <= '0;
            state   <= wrOnly ? ST_IDLE : ST_RD;
          end else begin
            reqAddr <= reqAddr + ADDR_W'(1);
          end
        end
        ST_RD: if (reqFire) begin
          if (lastReq) state <= ST_DRAIN;
          else         reqAddr <= reqAddr + ADDR_W'(1);
        end
        default: ;
      endcase
      if (rspFire) begin
        rspCnt <= rspCnt + CNT_W'(1);
        if (lastRsp) state <= ST_IDLE;
      end
    end
  end

  a_r2_addr_in_range: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid |-> ({1'b0, memReqAddr} < numAddr));
  a_r2_hold_on_stall: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid && !memReqReady) |=> (memReqValid && $stable(memReqAddr) && $stable(memReqWrite)));
  a_r3_rsp_bounded: assert property (@(posedge clk) disable iff (!rstN)
    st.busy |-> (rspCnt < numAddr));
  a_r3_start_busy: assert property (@(posedge clk) disable iff (!rstN)
    runStart |=> st.busy);
endmodule

// File: rtl/memtg_datapath.sv
module memtg_datapath
  import memtg_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int ADDR_W = 19,
  parameter int PASS_W = 16,
  parameter int STAT_W = 32,
  parameter int PEND_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       st,
  input  logic [1:0]        srcSel,
  input  logic [PASS_W-1:0] passSel,
  input  logic [ADDR_W-1:0] wrIdx,
  input  logic [ADDR_W-1:0] chkIdx,
  input  logic              injectReq,
  input  logic              clearErr,
  input  logic [DATA_W-1:0] memRspData,
  output logic [DATA_W-1:0] memReqData,
  output logic [STAT_W-1:0] errDetected,
  output logic [STAT_W-1:0] errInjected,
  output logic [STAT_W-1:0] bytesWritten,
  output logic [STAT_W-1:0] bytesRead
);
  localparam logic [STAT_W-1:0] STAT_MAX = '1;
  localparam int BYTES_PER_WORD = DATA_W / 8;

  logic [DATA_W-1:0] wrWord, expWord, expCmp;
  logic [PEND_W-1:0] pend, pendNext;
  logic pendAny, consume, accept, mismatch;

  memtg_pattern #(.DATA_W(DATA_W), .IDX_W(ADDR_W), .PASS_W(PASS_W)) wrGen_i (
    .clk(clk), .rstN(rstN), .restart(st.runStart), .advance(st.wrFire),
    .src(srcSel), .idx(wrIdx), .pass(passSel), .word(wrWord));

  memtg_pattern #(.DATA_W(DATA_W), .IDX_W(ADDR_W), .PASS_W(PASS_W)) expGen_i (
    .clk(clk), .rstN(rstN), .restart(st.runStart), .advance(st.rspFire),
    .src(srcSel), .idx(chkIdx), .pass(passSel), .word(expWord));

  assign pendAny  = (pend != '0);
  assign consume  = pendAny && (st.wrPhase ? st.wrFire : st.rspFire);
  assign accept   = injectReq && st.busy && !st.runEnd && ((pend != '1) || consume);
  assign pendNext = pend - PEND_W'(consume) + PEND_W'(accept);

  assign memReqData = wrWord ^ DATA_W'(pendAny && st.wrPhase);
  assign expCmp     = expWord ^ DATA_W'(pendAny && !st.wrPhase);
  assign mismatch   = st.rspFire && (memRspData != expCmp);

  function automatic logic [STAT_W-1:0] satAdd(input logic [STAT_W-1:0] a, input int unsigned b);
    logic [STAT_W:0] s;
    s = {1'b0, a} + (STAT_W+1)'(b);
    return s[STAT_W] ? STAT_MAX : s[STAT_W-1:0];
  endfunction

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pend         <= '0;
      errDetected  <= '0;
      errInjected  <= '0;
      bytesWritten <= '0;
      bytesRead    <= '0;
    end else begin
      pend <= st.runEnd ? '0 : pendNext;
      if (clearErr) begin
        errDetected <= '0;
        errInjected <= '0;
      end else begin
        if (mismatch) errDetected <= satAdd(errDetected, 1);
        if (consume)  errInjected <= satAdd(errInjected, 1);
      end
      if (st.runStart) begin
        bytesWritten <= '0;
        bytesRead    <= '0;
      end else begin
        if (st.wrFire)  bytesWritten <= satAdd(bytesWritten, BYTES_PER_WORD);
        if (st.rspFire) bytesRead    <= satAdd(bytesRead, BYTES_PER_WORD);
      end
    end
  end

  a_r11_clear_zero: assert property (@(posedge clk) disable iff (!rstN)
    clearErr |=> (errDetected == '0 && errInjected == '0));
  a_r8_inj_step: assert property (@(posedge clk) disable iff (!rstN)
    !clearErr |=> (errInjected == $past(errInjected) || errInjected == $past(errInjected) + STAT_W'(1)));
  a_r7_det_step: assert property (@(posedge clk) disable iff (!rstN)
    !clearErr |=> (errDetected == $past(errDetected) || errDetected == $past(errDetected) + STAT_W'(1)));
  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (!st.busy && !clearErr) |=> $stable(errInjected));
  a_r12_wr_saturate: assert property (@(posedge clk) disable iff (!rstN)
    (bytesWritten == STAT_MAX && !st.runStart) |=> bytesWritten == STAT_MAX);
  a_r12_rd_saturate: assert property (@(posedge clk) disable iff (!rstN)
    (bytesRead == STAT_MAX && !st.runStart) |=> bytesRead == STAT_MAX);
endmodule

// File: rtl/memtg_top.sv
module memtg_top
  import memtg_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int ADDR_W = 19,
  parameter int PASS_W = 16,
  parameter int STAT_W = 32,
  parameter int PEND_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startRun,
  input  logic [ADDR_W:0]   cfgNumAddr,
  input  logic [1:0]        cfgMode,
  input  logic [1:0]        cfgSrc,
  input  logic [PASS_W-1:0] cfgPass,
  input  logic              injectReq,
  input  logic              clearErr,
  output logic              memReqValid,
  input  logic              memReqReady,
  output logic              memReqWrite,
  output logic [ADDR_W-1:0] memReqAddr,
  output logic [DATA_W-1:0] memReqData,
  input  logic              memRspValid,
  input  logic [DATA_W-1:0] memRspData,
  output logic              busy,
  output logic [STAT_W-1:0] errDetected,
  output logic [STAT_W-1:0] errInjected,
  output logic [STAT_W-1:0] bytesWritten,
  output logic [STAT_W-1:0] bytesRead
);
  ctrlStrobe_t       st;
  logic [1:0]        srcSel;
  logic [PASS_W-1:0] passSel;
  logic [ADDR_W-1:0] chkIdx;

  memtg_ctrl #(.ADDR_W(ADDR_W), .PASS_W(PASS_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .startRun(startRun), .cfgNumAddr(cfgNumAddr),
    .cfgMode(cfgMode), .cfgSrc(cfgSrc), .cfgPass(cfgPass),
    .memReqReady(memReqReady), .memRspValid(memRspValid),
    .memReqValid(memReqValid), .memReqWrite(memReqWrite), .memReqAddr(memReqAddr),
    .chkIdx(chkIdx), .st(st), .srcSel(srcSel), .passSel(passSel));

  memtg_datapath #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .PASS_W(PASS_W),
                   .STAT_W(STAT_W), .PEND_W(PEND_W)) dp_i (
    .clk(clk), .rstN(rstN), .st(st), .srcSel(srcSel), .passSel(passSel),
    .wrIdx(memReqAddr), .chkIdx(chkIdx), .injectReq(injectReq), .clearErr(clearErr),
    .memRspData(memRspData), .memReqData(memReqData),
    .errDetected(errDetected), .errInjected(errInjected),
    .bytesWritten(bytesWritten), .bytesRead(bytesRead));

  assign busy = st.busy;
endmodule

// File: tb/memtg_top_tb_top.sv
module memtg_top_tb_top;
  localparam int LAT = 3;

  logic clk = 0, rstN = 0;
  logic startRun = 0, injectReq = 0, clearErr = 0;
  logic [19:0] cfgNumAddr = 20'd4;
  logic [1:0]  cfgMode = 0, cfgSrc = 0;
  logic [15:0] cfgPass = 0;
  logic memReqValid, memReqReady = 0, memReqWrite, memRspValid = 0, busy;
  logic [18:0] memReqAddr;
  logic [63:0] memReqData, memRspData = 0;
  logic [31:0] errDetected, errInjected, bytesWritten, bytesRead;

  int chkCnt = 0, errCnt = 0;
  bit  done = 0;

  always #2.5 clk = ~clk;

  memtg_top dut_i (.*);

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    chkCnt++;
    if (act !== exp) begin
      errCnt++;
      $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // ---- expected words from the requirements ----
  function automatic logic [30:0] lfsrAdv(logic [30:0] s);
    for (int k = 0; k < 32; k++) s = {s[29:0], s[30] ^ s[27]};
    return s;
  endfunction

  logic [63:0] expQ[$];
  function automatic void buildExp(int n, logic [1:0] src, logic [15:0] pass);
    logic [30:0] lo, hi;
    logic [63:0] w;
    lo = 31'h2AC35D17; hi = 31'h39D26C26;
    expQ.delete();
    for (int a = 0; a < n; a++) begin
      if (src == 0) begin
        w = {1'b0, hi, 1'b0, lo};
        lo = lfsrAdv(lo); hi = lfsrAdv(hi);
      end else if (src == 1) begin
        w = 64'h0123456789ABCDEF;
        for (int k = 0; k < (a % 16); k++) w = {w[59:0], w[63:60]};
      end else begin
        w = 64'(a) * 64'h9E3779B97F4A7C15 + 64'(pass);
      end
      expQ.push_back(w);
    end
  endfunction

  // ---- memory responder: ready pattern plus fixed-latency reads ----
  logic [63:0] mem [int];
  initial begin
    logic        pv [LAT];
    logic [63:0] pd [LAT];
    int cyc = 0;
    for (int i = 0; i < LAT; i++) begin pv[i] = 0; pd[i] = 0; end
    forever begin
      @(negedge clk);
      cyc++;
      memReqReady = (cyc % 5) != 3;
      memRspValid = pv[LAT-1];
      memRspData  = pd[LAT-1];
      for (int i = LAT-1; i > 0; i--) begin pv[i] = pv[i-1]; pd[i] = pd[i-1]; end
      pv[0] = 0; pd[0] = 0;
      if (rstN && memReqValid && memReqReady) begin
        if (memReqWrite) mem[int'(memReqAddr)] = memReqData;
        else begin
          pv[0] = 1;
          pd[0] = mem.exists(int'(memReqAddr)) ? mem[int'(memReqAddr)] : 64'h0;
        end
      end
    end
  end

  // ---- cycle-by-cycle behavioural model ----
  initial begin
    int phase = 0, n = 0, nWr = 0, nRd = 0, nRsp = 0, pend = 0;
    int mode = 0;
    logic [1:0] src = 0;
    logic [31:0] mDet = 0, mInj = 0, mWrB = 0, mRdB = 0;
    string dTag;
    wait (rstN);
    forever begin
      bit wrFire, rdFire, rspFire, ending, cons;
      logic [63:0] e;
      @(negedge clk); #1;
      dTag = (src == 0) ? "R4" : (src == 1) ? "R5" : "R6";
      chk("R3 busy", busy, phase != 0);
      chk("R2 reqValid", memReqValid, phase == 1 || phase == 2);
      if (memReqValid) chk("R3 reqWrite", memReqWrite, phase == 1);
      chk("R7 errDetected", errDetected, mDet);
      chk("R8 errInjected", errInjected, mInj);
      chk("R12 bytesWritten", bytesWritten, mWrB);
      chk("R12 bytesRead", bytesRead, mRdB);
      wrFire  = memReqValid && memReqReady && memReqWrite;
      rdFire  = memReqValid && memReqReady && !memReqWrite;
      rspFire = memRspValid && (phase == 2 || phase == 3);
      ending = 0; cons = 0;
      if (phase == 0) begin
        if (startRun) begin
          n = int'(cfgNumAddr);
          if (n < 2) n = 2;
          if (n > 524288) n = 524288;
          mode = int'(cfgMode); src = cfgSrc;
          buildExp(n, cfgSrc, cfgPass);
          nWr = 0; nRd = 0; nRsp = 0; mWrB = 0; mRdB = 0;
          phase = (mode == 1) ? 2 : 1;
        end
      end else begin
        if (wrFire) begin
          chk("R2 write address", memReqAddr, nWr);
          chk({dTag, " write data"}, memReqData, expQ[nWr] ^ 64'(pend > 0));
          if (pend > 0) cons = 1;
          mWrB += 8; nWr++;
          if (nWr == n) begin
            if (mode == 2) ending = 1; else phase = 2;
          end
        end
        if (rdFire) begin
          chk("R2 read address", memReqAddr, nRd);
          nRd++;
          if (nRd == n) phase = 3;
        end
        if (rspFire) begin
          e = expQ[nRsp] ^ 64'(pend > 0);
          if (pend > 0) cons = 1;
          if (memRspData != e) mDet++;
          mRdB += 8; nRsp++;
          if (nRsp == n) ending = 1;
        end
        if (cons) begin mInj++; pend--; end
        if (injectReq && !ending && pend < 15) pend++;
        if (ending) begin phase = 0; pend = 0; end
      end
      if (clearErr) begin mDet = 0; mInj = 0; end
    end
  end

  // ---- scenario helpers ----
  task automatic runPass(int n, int mode, int src, int pass, int injAt, int injAt2, bit reStart);
    int cyc = 1;
    @(negedge clk);
    cfgNumAddr = 20'(n); cfgMode = 2'(mode); cfgSrc = 2'(src); cfgPass = 16'(pass);
    startRun = 1;
    @(negedge clk);
    startRun = 0;
    while (busy) begin
      injectReq = (cyc == injAt) || (cyc == injAt2);
      startRun  = reStart && (cyc == 2);
      @(negedge clk);
      cyc++;
    end
    injectReq = 0; startRun = 0;
    repeat (2) @(negedge clk);
  endtask

  task automatic finishSim();
    $display("Result: errors=%0d of %0d checks", errCnt, chkCnt);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errCnt++;
      chkCnt++;
      $display("FAIL watchdog: actual=running expected=finished");
      finishSim();
    end
  end

  initial begin
    logic [31:0] d0, i0;
    repeat (3) @(negedge clk);
    // R1: state during and just after reset
    chk("R1 busy", busy, 0);
    chk("R1 reqValid", memReqValid, 0);
    chk("R1 errDetected", errDetected, 0);
    chk("R1 errInjected", errInjected, 0);
    chk("R1 bytesWritten", bytesWritten, 0);
    chk("R1 bytesRead", bytesRead, 0);
    rstN = 1;
    @(negedge clk);

    // R4: PRBS write then read, clean
    runPass(20, 0, 0, 0, 0, 0, 0);
    chk("R4 no mismatch", errDetected, 0);
    chk("R12 wr bytes", bytesWritten, 160);
    chk("R12 rd bytes", bytesRead, 160);

    // R5 + R8: table source, one injection in write phase
    runPass(37, 0, 1, 0, 3, 0, 0);
    chk("R8 injected", errInjected, 1);
    chk("R8 detected", errDetected, 1);

    // R6 + R3: arithmetic, write only, then read only with injection (R9)
    runPass(10, 2, 2, 5, 0, 0, 0);
    chk("R3 write only rd bytes", bytesRead, 0);
    chk("R3 write only wr bytes", bytesWritten, 80);
    runPass(10, 1, 2, 5, 2, 0, 0);
    chk("R9 injected", errInjected, 2);
    chk("R9 detected", errDetected, 2);
    chk("R3 read only wr bytes", bytesWritten, 0);

    // R7: wrong pass index -> every word mismatches
    runPass(10, 1, 2, 6, 0, 0, 0);
    chk("R7 all mismatch", errDetected, 12);

    // R11: clear
    @(negedge clk); clearErr = 1; @(negedge clk); clearErr = 0;
    chk("R11 det cleared", errDetected, 0);
    chk("R11 inj cleared", errInjected, 0);

    // R10: idle injection ignored, then a clean read-only pass
    injectReq = 1; repeat (3) @(negedge clk); injectReq = 0;
    @(negedge clk);
    chk("R10 idle inj", errInjected, 0);
    runPass(10, 1, 2, 5, 0, 0, 0);
    chk("R10 no stale corruption", errDetected, 0);
    chk("R10 no stale count", errInjected, 0);

    // R10: two requests in one pass corrupt two words
    runPass(20, 3, 1, 0, 3, 4, 0);
    chk("R10 two injected", errInjected, 2);
    chk("R10 two detected", errDetected, 2);

    // R2: clamp of pass length, and start while busy ignored
    runPass(0, 2, 0, 0, 0, 0, 0);
    chk("R2 clamp 0", bytesWritten, 16);
    runPass(1, 2, 0, 0, 0, 0, 0);
    chk("R2 clamp 1", bytesWritten, 16);
    runPass(6, 2, 0, 0, 0, 0, 1);
    chk("R2 restart ignored", bytesWritten, 48);
    chk("R2 idle after pass", busy, 0);

    done = 1;
    finishSim();
  end
endmodule